// File: doc/BRIEF.md
# Supply Supervisor Reset Controller

This block turns digitized supply-status signals into a clean, active-high system reset. A comparator flag reports whether the main supply is above its minimum trip level, and an external manual-reset request can force reset. Reset is held from power-up, and after any supply fault or manual request, until the main supply has stayed good for a continuous stretch period. Software picks that period from four choices.

Two auxiliary comparator flags are synchronized and then passed to their own outputs. Each flag also sets a sticky status bit. The bit stays set after the flag drops, so software can still see a fault that has since cleared. A small register port reads the stretch selection and the sticky bits. Writes to this port change the selection or clear status bits. Every asynchronous input passes through a two-flop synchronizer. The reset output comes straight from a flop, so it cannot glitch.

Top module: `supply_supervisor`

## Requirements
- R1: While `rst_n` is low, `sys_reset` is 1. It stays 1 after `rst_n` is released until a full stretch period completes.
- R2: `sys_reset` falls exactly N+2 clock edges after the first edge that samples `main_good` high. N is the selected period in cycles, and the extra 2 edges come from the synchronizer.
- R3: When `main_good` drops, `sys_reset` is 1 from the third clock edge after that onward. It stays 0 through the second edge.
- R4: Any loss of `main_good` during the stretch restarts the count from zero, even a loss lasting one cycle. The full N+2 edges are then counted again from the moment `main_good` is restored.
- R5: While `manual_rst` is held, `sys_reset` stays 1. After `manual_rst` is released, `sys_reset` falls N+2 edges later.
- R6: The stretch selection is a 2-bit field at register address 0, bits [1:0]. The codes are 0=50 ms, 1=100 ms, 2=200 ms, 3=300 ms. N = ms × `CYC_PER_MS`. The field resets to 1, and it reads back what was written.
- R7: `aux_fail[i]` equals `aux_above[i]` delayed by two clock edges.
- R8: Status register address 1, bit i, is set when the synchronized `aux_above[i]` is 1. The bit stays set after the flag returns to 0.
- R9: Writing address 1 clears each status bit whose write-data bit is 1, and leaves bits written with 0 unchanged. If a bit's flag is high in the same cycle as its clear, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| main_good | input | 1 | Main supply above trip level (asynchronous) |
| aux_above | input | 2 | Auxiliary comparator flags (asynchronous) |
| manual_rst | input | 1 | External reset request, active high (asynchronous) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 = stretch select, 1 = status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| sys_reset | output | 1 | System reset, active high, from a flop |
| aux_fail | output | 2 | Synchronized auxiliary flags |

## Verification
The assertions assume that the asynchronous inputs are already clean levels when they leave the synchronizers. They also assume that the register port is a single-cycle strobe with stable address and data. The stimulus changes every input only on the falling clock edge and pulses `reg_wr` for exactly one cycle. Each supply or manual-reset event is held for at least one full cycle, so the synchronizer output sees every event the bench intends.

// File: rtl/ssv_pkg.sv
package ssv_pkg;
  typedef enum logic [1:0] {
    STR_50MS  = 2'd0,
    STR_100MS = 2'd1,
    STR_200MS = 2'd2,
    STR_300MS = 2'd3
  } stretch_sel_e;

  localparam int MAX_MS = 300;
  localparam logic ADDR_SEL    = 1'b0;
  localparam logic ADDR_STATUS = 1'b1;

  function automatic int stretch_ms(stretch_sel_e sel);
    case (sel)
      STR_50MS:  return 50;
      STR_100MS: return 100;
      STR_200MS: return 200;
      default:   return 300;
    endcase
  endfunction
endpackage

// File: rtl/ssv_sync.sv
module ssv_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_sync <= '0;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end
endmodule

// File: rtl/ssv_stretch.sv
module ssv_stretch
  import ssv_pkg::*;
#(
  parameter int CYC_PER_MS = 100000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         supply_ok,
  input  logic         force_rst,
  input  stretch_sel_e sel,
  output logic         rst_out
);
  localparam int MAX_CYC = MAX_MS * CYC_PER_MS;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] stable_cnt;
  logic [CNT_W-1:0] last_cnt;
  logic             hold;

  assign last_cnt = CNT_W'(stretch_ms(sel) * CYC_PER_MS - 1);
  assign hold     = !supply_ok || force_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_cnt <= '0;
      rst_out    <= 1'b1;
    end else if (hold) begin
      stable_cnt <= '0;
      rst_out    <= 1'b1;
    end else if (rst_out) begin
      if (stable_cnt >= last_cnt) rst_out <= 1'b0;
      else                        stable_cnt <= stable_cnt + 1'b1;
    end
  end

  AST_SUPPLY_LOSS_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> rst_out); // R3
  AST_MANUAL_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    force_rst |=> rst_out); // R5
  AST_RELEASE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> $past(supply_ok) && !$past(force_rst)); // R2
  AST_NO_REASSERT_WHEN_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out && supply_ok && !force_rst) |=> !rst_out); // R4
endmodule

// File: rtl/ssv_sticky.sv
module ssv_sticky #(
  parameter int N_MON = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MON-1:0] mon,
  input  logic [N_MON-1:0] clr,
  output logic [N_MON-1:0] flags
);
  for (genvar i = 0; i < N_MON; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (mon[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr[i]) |=> flags[i]); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      mon[i] |=> flags[i]); // R9
  end
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import ssv_pkg::*;
#(
  parameter int CYC_PER_MS = 100000,
  parameter int N_AUX      = 2,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              main_good,
  input  logic [N_AUX-1:0]  aux_above,
  input  logic              manual_rst,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sys_reset,
  output logic [N_AUX-1:0]  aux_fail
);
  localparam int IN_W = N_AUX + 2;

  logic [IN_W-1:0]  raw_in;
  logic [IN_W-1:0]  sync_in;
  logic             main_s;
  logic             mr_s;
  logic [N_AUX-1:0] aux_s;
  logic [N_AUX-1:0] status;
  logic [N_AUX-1:0] clr_mask;
  stretch_sel_e     sel_q;

  assign raw_in = {manual_rst, main_good, aux_above};

  ssv_sync #(.WIDTH(IN_W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(raw_in),
    .q_sync (sync_in)
  );

  assign aux_s    = sync_in[N_AUX-1:0];
  assign main_s   = sync_in[N_AUX];
  assign mr_s     = sync_in[N_AUX+1];
  assign aux_fail = aux_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= STR_100MS;
    else if (reg_wr && reg_addr == ADDR_SEL)
      sel_q <= stretch_sel_e'(reg_wdata[1:0]);
  end

  assign clr_mask = (reg_wr && reg_addr == ADDR_STATUS) ? reg_wdata[N_AUX-1:0] : '0;

  ssv_stretch #(.CYC_PER_MS(CYC_PER_MS)) u_stretch (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(main_s),
    .force_rst(mr_s),
    .sel      (sel_q),
    .rst_out  (sys_reset)
  );

  ssv_sticky #(.N_MON(N_AUX)) u_sticky (
    .clk  (clk),
    .rst_n(rst_n),
    .mon  (aux_s),
    .clr  (clr_mask),
    .flags(status)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_STATUS) reg_rdata[N_AUX-1:0] = status;
    else                         reg_rdata[1:0]       = sel_q;
  end

  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(sel_q)); // R6
endmodule

// File: tb/test_supply_supervisor.sv
module test_supply_supervisor;
  localparam int PERIOD = 10;
  localparam int CPM    = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_good = 1'b0;
  logic [1:0] aux_above = 2'b00;
  logic       manual_rst = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sys_reset;
  logic [1:0] aux_fail;

  int    n_run = 0;
  int    n_fail = 0;
  bit    ended = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  supply_supervisor #(.CYC_PER_MS(CPM)) i_supply_supervisor (
    .clk(clk), .rst_n(rst_n), .main_good(main_good), .aux_above(aux_above),
    .manual_rst(manual_rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_reset(sys_reset),
    .aux_fail(aux_fail)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic reg_read(input logic a, output int v);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  // driver: push the expected release latency, then apply the stimulus
  task automatic expect_release(input int lat, input string req);
    exp_q.push_back(lat);
    tag_q.push_back(req);
  endtask

  task automatic wait_drained();
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  // monitor: count edges until reset is seen low
  initial begin
    forever begin
      int n;
      wait (exp_q.size() > 0);
      n = 0;
      do begin
        @(posedge clk); n++;
        @(negedge clk);
      end while (sys_reset && n < 5000);
      check(tag_q[0], n, exp_q[0]);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!ended) begin
      ended = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    cycles(3);
    check("R1 reset held", int'(sys_reset), 1);
    reg_read(1'b0, v);
    check("R6 default select", v, 1);
    rst_n = 1'b1;
    cycles(5);
    check("R1 reset held after release", int'(sys_reset), 1);

    // R7 auxiliary passthrough latency
    aux_above = 2'b01;
    cycles(1);
    check("R7 not yet", int'(aux_fail), 0);
    cycles(1);
    check("R7 passthrough", int'(aux_fail), 1);
    aux_above = 2'b00;
    cycles(3);
    check("R7 follows low", int'(aux_fail), 0);
    reg_read(1'b1, v);
    check("R8 sticky after clear of flag", v, 1);

    // R9 write-one-to-clear
    reg_write(1'b1, 8'h02);
    reg_read(1'b1, v);
    check("R9 zero bit ignored", v, 1);
    reg_write(1'b1, 8'h01);
    reg_read(1'b1, v);
    check("R9 clear", v, 0);
    aux_above = 2'b10;
    cycles(3);
    reg_write(1'b1, 8'h02);
    reg_read(1'b1, v);
    check("R9 set wins over clear", v, 2);
    aux_above = 2'b00;
    cycles(3);
    reg_write(1'b1, 8'h02);
    reg_read(1'b1, v);
    check("R9 clear after flag low", v, 0);

    // R2 power-up stretch at 100 ms
    expect_release(100 * CPM + 2, "R2 release latency");
    main_good = 1'b1;
    wait_drained();
    check("R2 reset low", int'(sys_reset), 0);

    // R3 supply loss
    main_good = 1'b0;
    cycles(2);
    check("R3 still low at edge 2", int'(sys_reset), 0);
    cycles(1);
    check("R3 asserted at edge 3", int'(sys_reset), 1);

    // R4 dropout restarts
    main_good = 1'b1;
    cycles(80);
    main_good = 1'b0;
    cycles(1);
    expect_release(100 * CPM + 2, "R4 restart after dropout");
    main_good = 1'b1;
    wait_drained();

    // R6 selections
    for (int s = 0; s < 4; s++) begin
      int ms;
      ms = (s == 0) ? 50 : (s == 1) ? 100 : (s == 2) ? 200 : 300;
      reg_write(1'b0, 8'(s));
      reg_read(1'b0, v);
      check("R6 select readback", v, s);
      main_good = 1'b0;
      cycles(4);
      expect_release(ms * CPM + 2, "R6 selected period");
      main_good = 1'b1;
      wait_drained();
    end

    // R5 manual reset
    reg_write(1'b0, 8'h00);
    manual_rst = 1'b1;
    cycles(3);
    check("R5 forced high", int'(sys_reset), 1);
    cycles(50);
    check("R5 held high", int'(sys_reset), 1);
    expect_release(50 * CPM + 2, "R5 stretch after release");
    manual_rst = 1'b0;
    wait_drained();

    ended = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule